// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory

This block is a synthesizable model of a bit-serial configuration store, as an FPGA sees it when it pulls its own configuration in master serial mode. An array of single-bit words is read out one bit per clock, lowest address first. The position comes from an internal address counter, which advances on each clock edge while the block is selected and its output is enabled. The serial output is modelled as a data bit plus a drive-enable bit, so high impedance is explicit.

Several blocks form a longer store by chaining the end-of-memory output of one into the chip-select of the next. When a block has sent its last bit, it stops driving and pulls its chain output low, and the next block takes over the line in the following cycle. A single pin carries both the counter reset and the output enable. Its polarity comes from a stored configuration bit. A power-on counter holds a ready flag low for a fixed number of cycles. A serial-enable input switches the block into programming mode, where a plain parallel port fills the array.

Top module: `cfg_serial_mem`

## Requirements
- R1: After `arst_n` is released, `ready` stays low for exactly POR_CYCLES rising clock edges and then stays high. While it is low, `data_oe` is 0, `ceo_n` is 1 and the counter is held at address 0.
- R2: A clock edge with `rst_oe` at its reset level clears the address counter and the end state, whatever `ce_n` is. In any cycle where `rst_oe` is at its reset level, `data_oe` is 0.
- R3: With `ready`=1, `ser_en`=1, `ce_n`=0 and `rst_oe` at its active level, `data_oe` is 1 and `data_o` equals the array bit at the current address. The address starts at 0 and rises by one per clock edge.
- R4: With `ce_n`=1 the block stops driving (`data_oe`=0) and the counter holds. When `ce_n` returns low, output resumes at the bit where it stopped.
- R5: The clock edge that consumes bit DEPTH-1 enters an end state: `data_oe` is 0 and the counter does not wrap to 0. Only a reset level or programming mode leaves this state.
- R6: In the end state, `ceo_n` is low exactly while `ce_n` is low and `rst_oe` is active. Once a reset level has been applied, `ceo_n` stays high until all DEPTH bits have been clocked out again.
- R7: The polarity bit is written from `pol_val` when `pol_we`=1 in programming mode, and it is 0 after `arst_n`. With 0, `rst_oe`=0 is the reset level and `rst_oe`=1 enables output. With 1, these are swapped.
- R8: With `ser_en`=0, `data_oe` is 0, `ceo_n` is 1, `ce_n` has no effect and the counter is cleared. `pre_we` writes `pre_data` to array address `pre_addr` only in this mode. With `ser_en`=1 it is ignored.
- R9: In a chain where one block's `ceo_n` feeds the next block's `ce_n`, the two arrays come out as one unbroken bit stream. In every cycle of that stream exactly one block drives, and after the last bit neither drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| ser_en | input | 1 | 1 = configuration read mode, 0 = programming mode |
| ce_n | input | 1 | Chip select, active low |
| rst_oe | input | 1 | Shared counter reset / output enable, polarity set by the stored bit |
| pol_we | input | 1 | Write strobe for the polarity bit (programming mode only) |
| pol_val | input | 1 | Value written to the polarity bit |
| pre_we | input | 1 | Array preload write strobe (programming mode only) |
| pre_addr | input | AW | Preload address |
| pre_data | input | 1 | Preload data bit |
| data_o | output | 1 | Serial data bit (valid when data_oe is 1) |
| data_oe | output | 1 | Serial data drive enable; 0 means high impedance |
| ceo_n | output | 1 | Chain select output to the next block, active low |
| ready | output | 1 | Power-on reset complete |

## Verification
The embedded properties check the following on every cycle:
- The ready flag never falls once it has risen.
- A reset level or programming mode always leaves the counter at zero.
- An enabled read step always increments the address by one.
- A deselected block holds its position.
- The end state is sticky.
- A block never drives data while its chain output is low.

Only the bench scenarios can show the rest: the actual bit stream across a two-block chain for several patterns, the exact cycle of the hand-off, the chain output following the select and then staying high through a full re-read, the effect of the polarity bit, and that preload writes outside programming mode leave the array unchanged.

// File: rtl/cfg_serial_mem.sv
module cfg_serial_mem #(
  parameter int DEPTH      = 64,
  parameter int POR_CYCLES = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW = $clog2(POR_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          ser_en,
  input  logic          ce_n,
  input  logic          rst_oe,
  input  logic          pol_we,
  input  logic          pol_val,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic          pre_data,
  output logic          data_o,
  output logic          data_oe,
  output logic          ceo_n,
  output logic          ready
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    addr;
  logic [PW-1:0]    por_cnt;
  logic             done, ready_q, pol;
  logic             oe_act, rd_mode, rd_en, clr;

  assign oe_act  = pol ? ~rst_oe : rst_oe;
  assign rd_mode = ready_q & ser_en;
  assign rd_en   = rd_mode & ~ce_n & oe_act & ~done;
  assign clr     = ~ready_q | ~ser_en | ~oe_act;

  assign ready   = ready_q;
  assign data_oe = rd_en;
  assign data_o  = rd_en ? mem[addr] : 1'b0;
  assign ceo_n   = ~(rd_mode & done & oe_act & ~ce_n);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      por_cnt <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      if (por_cnt == PW'(POR_CYCLES - 1)) ready_q <= 1'b1;
      por_cnt <= por_cnt + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      addr <= '0;
      done <= 1'b0;
    end else if (clr) begin
      addr <= '0;
      done <= 1'b0;
    end else if (rd_en) begin
      if (addr == LAST) done <= 1'b1;
      else              addr <= addr + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                        pol <= 1'b0;
    else if (ready_q && !ser_en && pol_we) pol <= pol_val;
  end

  always_ff @(posedge clk) begin
    if (!ser_en && pre_we) mem[pre_addr] <= pre_data;
  end

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ready_q |=> ready_q);

  // R1
  por_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !ready_q |-> (addr == '0) && ceo_n && !data_oe);

  // R2
  reset_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (ready_q && ser_en && !oe_act) |=> (addr == '0) && !done);

  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (data_oe && addr != LAST) |=> addr == $past(addr) + AW'(1));

  // R4
  standby_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (ready_q && ser_en && oe_act && ce_n) |=> $stable(addr) && $stable(done));

  // R5
  end_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (done && rd_mode && oe_act) |=> done && (addr == LAST));

  // R6
  handoff_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !ceo_n |-> !data_oe);

  // R8
  prog_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !ser_en |=> (addr == '0) && !done);

endmodule

// File: tb/cfg_serial_mem_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_mem_tb_top;
  localparam int D = 16;
  localparam int P = 4;
  localparam logic [31:0] VEC [4] = '{32'hA5C3_0FF0, 32'h0000_FFFF,
                                      32'h1234_8001, 32'h3C96_5AA5};

  logic clk = 0, arst_n = 0, ser_en = 1, ce_n = 1, rst_oe = 1;
  logic pol_we = 0, pol_val = 0, pre_we_a = 0, pre_we_b = 0, pre_data = 0;
  logic [3:0] pre_addr = 0;
  logic a_d, a_oe, ceo_a, rdy_a, b_d, b_oe, ceo_b, rdy_b;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cfg_serial_mem #(.DEPTH(D), .POR_CYCLES(P)) dut_i (
    .clk(clk), .arst_n(arst_n), .ser_en(ser_en), .ce_n(ce_n), .rst_oe(rst_oe),
    .pol_we(pol_we), .pol_val(pol_val), .pre_we(pre_we_a), .pre_addr(pre_addr),
    .pre_data(pre_data), .data_o(a_d), .data_oe(a_oe), .ceo_n(ceo_a), .ready(rdy_a));

  cfg_serial_mem #(.DEPTH(D), .POR_CYCLES(P)) u_next (
    .clk(clk), .arst_n(arst_n), .ser_en(ser_en), .ce_n(ceo_a), .rst_oe(rst_oe),
    .pol_we(pol_we), .pol_val(pol_val), .pre_we(pre_we_b), .pre_addr(pre_addr),
    .pre_data(pre_data), .data_o(b_d), .data_oe(b_oe), .ceo_n(ceo_b), .ready(rdy_b));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic preload(input logic [15:0] wa, input logic [15:0] wb);
    nxt(); ser_en = 0;
    for (int i = 0; i < D; i++) begin
      nxt(); pre_we_a = 1; pre_we_b = 0; pre_addr = 4'(i); pre_data = wa[i];
    end
    for (int i = 0; i < D; i++) begin
      nxt(); pre_we_a = 0; pre_we_b = 1; pre_addr = 4'(i); pre_data = wb[i];
    end
    nxt(); pre_we_b = 0;
  endtask

  task automatic read_chain(input logic [31:0] w);
    for (int i = 0; i < 2*D; i++) begin
      #1;
      chk(32'(a_oe) + 32'(b_oe), 1, "R9 one driver");
      chk(a_oe ? a_d : b_d, w[i], i < D ? "R3 stream bit" : "R9 stream bit");
      nxt();
    end
    #1;
    chk({a_oe, b_oe, ceo_a, ceo_b}, 4'b0000, "R5 end state");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] wa;
    repeat (3) nxt();
    #1;
    chk({rdy_a, a_oe, ceo_a}, 3'b001, "R1 reset state");
    nxt(); arst_n = 1; ce_n = 0;
    for (int k = 1; k < P; k++) begin
      nxt(); #1;
      chk({rdy_a, a_oe, ceo_a}, 3'b001, "R1 por hold");
    end
    nxt(); #1;
    chk(rdy_a, 1, "R1 ready high");
    ce_n = 1;

    for (int v = 0; v < 4; v++) begin
      preload(VEC[v][15:0], VEC[v][31:16]);
      ser_en = 1; ce_n = 0; rst_oe = 1;
      read_chain(VEC[v]);
      nxt(); rst_oe = 0;
      nxt(); rst_oe = 1; ce_n = 1;
    end
    wa = VEC[3][15:0];

    nxt(); ce_n = 0; #1; chk(a_d, wa[0], "R4 bit0");
    nxt(); #1; chk(a_d, wa[1], "R4 bit1");
    nxt(); ce_n = 1; #1; chk(a_oe, 0, "R4 deselect");
    nxt(); #1; chk(a_oe, 0, "R4 hold");
    nxt(); ce_n = 0; #1; chk({a_oe, a_d}, {1'b1, wa[2]}, "R4 resume");

    nxt(); ce_n = 1; rst_oe = 0; #1; chk(a_oe, 0, "R2 reset deselected");
    nxt(); rst_oe = 1; ce_n = 0; #1; chk({a_oe, a_d}, {1'b1, wa[0]}, "R2 cleared");
    nxt();
    nxt(); rst_oe = 0; #1; chk(a_oe, 0, "R2 reset selected");
    nxt(); rst_oe = 1; #1; chk({a_oe, a_d}, {1'b1, wa[0]}, "R2 cleared again");

    for (int i = 0; i < D; i++) nxt();
    #1; chk({a_oe, ceo_a}, 2'b00, "R5 done");
    nxt(); ce_n = 1; #1; chk(ceo_a, 1, "R6 follow high");
    nxt(); #1; chk(ceo_a, 1, "R6 follow hold");
    nxt(); ce_n = 0; #1; chk({a_oe, ceo_a}, 2'b00, "R5 no wrap");
    nxt(); rst_oe = 0; #1; chk(ceo_a, 1, "R6 oe inactive");
    nxt(); rst_oe = 1; #1; chk({a_oe, ceo_a, a_d}, {2'b11, wa[0]}, "R6 reread");
    for (int i = 1; i < D; i++) begin
      nxt(); #1; chk(ceo_a, 1, "R6 high during reread");
    end
    nxt(); #1; chk(ceo_a, 0, "R6 low after reread");
    nxt(); rst_oe = 0;
    nxt(); rst_oe = 1;

    nxt(); ser_en = 0; #1; chk({a_oe, ceo_a}, 2'b01, "R8 prog quiet");
    nxt(); ser_en = 1; pre_we_a = 1; pre_addr = 0; pre_data = ~wa[0];
    nxt(); pre_we_a = 0; rst_oe = 0;
    nxt(); rst_oe = 1; #1; chk(a_d, wa[0], "R8 write ignored");

    nxt(); ser_en = 0; pol_we = 1; pol_val = 1;
    nxt(); pol_we = 0; ser_en = 1; rst_oe = 0; ce_n = 0;
    #1; chk({a_oe, a_d}, {1'b1, wa[0]}, "R7 low enables");
    nxt(); rst_oe = 1; #1; chk(a_oe, 0, "R7 high resets");
    nxt(); rst_oe = 0; #1; chk({a_oe, a_d}, {1'b1, wa[0]}, "R7 cleared");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule